// File: doc/BRIEF.md
# Two-Thread Weighted Dispatch Arbiter

This block sits at the dispatch stage of a core that runs two hardware threads at once. In every cycle it picks at most one thread, and that thread sends one instruction group of 1 to 5 instructions into the pipeline. Each thread has a 5-bit weight. Over a scheduling round, each thread gets as many grants as its weight, so the share of dispatch slots follows the ratio of the two weights. When both weights are equal, the grants alternate cycle by cycle. A weight of 31 shuts the other thread out completely. A weight of 0 switches a thread off.

Each thread offers a group on a valid/ready pair. `thr_valid_i[t]` says that thread `t` has a group ready, and `thr_size_i[t]` gives its instruction count. `grant_o[t]` is the ready for that thread, and it is driven in the same cycle from the current inputs. A group moves on a cycle where valid and grant are both high. A thread that holds a group and sees no grant must keep that group offered; the arbiter itself never stores anything. If the thread whose turn it is holds its valid low, the other thread takes the slot. That borrowed slot costs the owner none of its share. The arbiter also keeps a running instruction count for each thread and raises a starvation flag for each thread.

Top module: `smt_dispatch_arb`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle, and `grant_o[t]` is high only when `thr_valid_i[t]` is high. If neither valid is high, no grant is issued.
- R2: When both weights are equal and nonzero and both threads stay valid, grants alternate every cycle. Thread 0 gets the first grant after reset.
- R3: A round begins when no enabled thread has credit left and some enabled thread is valid. At that point each thread's credit is loaded with its weight. Each ordinary grant takes one credit. Among the candidates, the thread with more credit left wins, and a tie goes to the thread that was not granted last. With weights 4 and 2 and both threads valid, 12 cycles give 8 and 4 grants.
- R4: When one weight is 31 and the other is below 31, the lower thread is treated as weight 0 for that round and gets no grant. If both weights are 31, the threads share the slots equally.
- R5: A thread whose weight is 0 at round start is never granted during that round, even when the other thread is stalled.
- R6: When every thread that still has credit is stalled, an enabled valid thread with no credit left takes the slot. No credit is consumed, and the stalled thread keeps its remaining share for when it becomes valid again.
- R7: A cycle with no grant leaves the credit state unchanged.
- R8: A weight change takes effect only when the next round begins. The credits of the current round finish as they were loaded.
- R9: `dispatch_cnt_o[t]` adds `thr_size_i[t]` on the clock edge that ends a granted cycle and holds otherwise. It wraps modulo 2^CNT_W.
- R10: `starve_o[t]` goes high in the cycle after thread `t` has been valid without a grant for 64 consecutive cycles. It stays high while that condition lasts. It drops in the cycle after a grant or after a cycle with the thread not valid.
- R11: After reset there is no credit, both counters read zero, both starvation flags are low, and the tie-break favours thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_valid_i | input | 2 | Per-thread group-offered flag (valid) |
| thr_prio_i | input | 2x5 | Per-thread dispatch weight, 0 to 31 |
| thr_size_i | input | 2x3 | Per-thread instruction count of the offered group, 1 to 5 |
| grant_o | output | 2 | Per-thread grant (ready), one-hot or zero |
| dispatch_cnt_o | output | 2x16 | Per-thread running count of dispatched instructions |
| starve_o | output | 2 | Per-thread starvation flag |

## Verification
`grant_o` depends combinationally on the inputs and on the credit registers, so it is due in the same cycle as the valid and weight values that produce it. `dispatch_cnt_o` and `starve_o` each pass through one register, so they show the effect of a cycle one clock edge later. The bench drives inputs just after each rising edge and samples every output on the falling edge. At that point it compares against a behavioural model whose state advances only on the rising edge, so each result is checked in the cycle it is due. The directed scenarios also count grants over windows that start at a known round boundary.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int NTHR = 2;

  typedef enum logic [1:0] {
    SEL_IDLE    = 2'd0,
    SEL_CREDIT  = 2'd1,
    SEL_HANDOFF = 2'd2,
    SEL_RELOAD  = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/smt_arb_select.sv
module smt_arb_select
  import smt_arb_pkg::*;
#(
  parameter int PRIO_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NTHR-1:0]               valid_i,
  input  logic [NTHR-1:0][PRIO_W-1:0]   prio_i,
  output logic [NTHR-1:0]               grant_o
);
  localparam logic [PRIO_W-1:0] PRIO_TOP = {PRIO_W{1'b1}};

  logic [NTHR-1:0][PRIO_W-1:0] rnd_prio_q, credit_q, credit_d, fresh_prio;
  logic [NTHR-1:0]             holds, active, fresh_cand, enabled;
  logic                        last_t1_q;
  sel_mode_e                   mode;

  // Per-thread round bookkeeping; a top weight masks a lower peer.
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    localparam int PEER = NTHR - 1 - t;
    assign fresh_prio[t] = (prio_i[PEER] == PRIO_TOP && prio_i[t] != PRIO_TOP)
                           ? '0 : prio_i[t];
    assign enabled[t]    = (rnd_prio_q[t] != '0);
    assign holds[t]      = enabled[t] && (credit_q[t] != '0);
    assign active[t]     = holds[t] && valid_i[t];
    assign fresh_cand[t] = valid_i[t] && (fresh_prio[t] != '0);
  end

  function automatic logic [NTHR-1:0] pick(
    input logic [NTHR-1:0]   cand,
    input logic [PRIO_W-1:0] c0,
    input logic [PRIO_W-1:0] c1,
    input logic              last1
  );
    if (cand == 2'b00) return 2'b00;
    if (cand == 2'b01) return 2'b01;
    if (cand == 2'b10) return 2'b10;
    if (c0 > c1)       return 2'b01;
    if (c1 > c0)       return 2'b10;
    return last1 ? 2'b01 : 2'b10;
  endfunction

  always_comb begin
    mode    = SEL_IDLE;
    grant_o = '0;
    if (|active) begin
      mode    = SEL_CREDIT;
      grant_o = pick(active, credit_q[0], credit_q[1], last_t1_q);
    end else if (|holds) begin
      mode    = SEL_HANDOFF;
      grant_o = pick(valid_i & enabled, credit_q[0], credit_q[1], last_t1_q);
    end else if (|fresh_cand) begin
      mode    = SEL_RELOAD;
      grant_o = pick(fresh_cand, fresh_prio[0], fresh_prio[1], last_t1_q);
    end
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      credit_d[t] = (mode == SEL_RELOAD) ? fresh_prio[t] : credit_q[t];
      if ((mode == SEL_RELOAD || mode == SEL_CREDIT) && grant_o[t])
        credit_d[t] = credit_d[t] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd_prio_q <= '0;
      credit_q   <= '0;
      last_t1_q  <= 1'b1;
    end else begin
      credit_q <= credit_d;
      if (mode == SEL_RELOAD) rnd_prio_q <= fresh_prio;
      if (|grant_o)           last_t1_q  <= grant_o[1];
    end
  end
endmodule

// File: rtl/smt_arb_tally.sv
module smt_arb_tally #(
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [CNT_W-1:0]  count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (take_i) count_o <= count_o + CNT_W'(size_i);
  end
endmodule

// File: rtl/smt_arb_starve.sv
module smt_arb_starve #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic got_i,
  output logic flag_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !want_i || got_i) wait_q <= '0;
    else if (wait_q != LIM)         wait_q <= wait_q + 1'b1;
  end

  assign flag_o = (wait_q == LIM);
endmodule

// File: rtl/smt_dispatch_arb.sv
module smt_dispatch_arb
  import smt_arb_pkg::*;
#(
  parameter int PRIO_W       = 5,
  parameter int SIZE_W       = 3,
  parameter int CNT_W        = 16,
  parameter int STARVE_LIMIT = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NTHR-1:0]             thr_valid_i,
  input  logic [NTHR-1:0][PRIO_W-1:0] thr_prio_i,
  input  logic [NTHR-1:0][SIZE_W-1:0] thr_size_i,
  output logic [NTHR-1:0]             grant_o,
  output logic [NTHR-1:0][CNT_W-1:0]  dispatch_cnt_o,
  output logic [NTHR-1:0]             starve_o
);
  smt_arb_select #(.PRIO_W(PRIO_W)) sel_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (thr_valid_i),
    .prio_i  (thr_prio_i),
    .grant_o (grant_o)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    smt_arb_tally #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) tally_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (grant_o[t]),
      .size_i  (thr_size_i[t]),
      .count_o (dispatch_cnt_o[t])
    );

    smt_arb_starve #(.LIMIT(STARVE_LIMIT)) starve_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_i (thr_valid_i[t]),
      .got_i  (grant_o[t]),
      .flag_o (starve_o[t])
    );
  end
endmodule

// File: rtl/smt_dispatch_arb_chk.sv
module smt_dispatch_arb_chk
  import smt_arb_pkg::*;
#(
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NTHR-1:0]             thr_valid_i,
  input logic [NTHR-1:0][SIZE_W-1:0] thr_size_i,
  input logic [NTHR-1:0]             grant_o,
  input logic [NTHR-1:0][CNT_W-1:0]  dispatch_cnt_o,
  input logic [NTHR-1:0]             starve_o
);
  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    p_grant_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[t] |-> thr_valid_i[t]);

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[t] |=> dispatch_cnt_o[t] ==
        $past(dispatch_cnt_o[t]) + CNT_W'($past(thr_size_i[t])));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_o[t] |=> $stable(dispatch_cnt_o[t]));

    p_starve_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[t] || !thr_valid_i[t]) |=> !starve_o[t]);

    p_starve_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      starve_o[t] |-> ($past(thr_valid_i[t]) && !$past(grant_o[t])));
  end
endmodule

bind smt_dispatch_arb smt_dispatch_arb_chk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .thr_valid_i    (thr_valid_i),
  .thr_size_i     (thr_size_i),
  .grant_o        (grant_o),
  .dispatch_cnt_o (dispatch_cnt_o),
  .starve_o       (starve_o)
);

// File: tb/smt_dispatch_arb_tb_top.sv
`timescale 1ns/1ps
module smt_dispatch_arb_tb_top;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      thr_valid_i = '0;
  logic [1:0][4:0] thr_prio_i = '0;
  logic [1:0][2:0] thr_size_i = '0;
  logic [1:0]      grant_o;
  logic [1:0][15:0] dispatch_cnt_o;
  logic [1:0]      starve_o;

  always #2.5 clk = ~clk;

  smt_dispatch_arb dut_i (
    .clk(clk), .rst_n(rst_n), .thr_valid_i(thr_valid_i), .thr_prio_i(thr_prio_i),
    .thr_size_i(thr_size_i), .grant_o(grant_o), .dispatch_cnt_o(dispatch_cnt_o),
    .starve_o(starve_o));

  int n_tests = 0, n_fail = 0, cycles = 0;
  string tag = "R11";
  int win0 = 0, win1 = 0, seen = 0;

  // behavioural reference state
  int m_rp[2], m_cr[2], m_cnt[2], m_sc[2], nrp[2];
  int m_last = 1, m_g = -1, m_mode = 0;

  task automatic chk(input string t, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int mpick(input bit a0, input bit a1, input int c0, input int c1, input int last);
    if (!a0 && !a1) return -1;
    if (a0 && !a1) return 0;
    if (!a0 && a1) return 1;
    if (c0 > c1) return 0;
    if (c1 > c0) return 1;
    return (last == 1) ? 0 : 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit v0, v1, h0, h1;
      v0 = thr_valid_i[0]; v1 = thr_valid_i[1];
      for (int t = 0; t < 2; t++)
        nrp[t] = (thr_prio_i[1-t] == 31 && thr_prio_i[t] != 31) ? 0 : int'(thr_prio_i[t]);
      h0 = m_rp[0] > 0 && m_cr[0] > 0;
      h1 = m_rp[1] > 0 && m_cr[1] > 0;
      m_g = -1; m_mode = 0;
      if ((h0 && v0) || (h1 && v1)) begin
        m_mode = 1; m_g = mpick(h0 && v0, h1 && v1, m_cr[0], m_cr[1], m_last);
      end else if (h0 || h1) begin
        m_mode = 2; m_g = mpick(v0 && m_rp[0] > 0, v1 && m_rp[1] > 0, m_cr[0], m_cr[1], m_last);
      end else if ((v0 && nrp[0] > 0) || (v1 && nrp[1] > 0)) begin
        m_mode = 3; m_g = mpick(v0 && nrp[0] > 0, v1 && nrp[1] > 0, nrp[0], nrp[1], m_last);
      end
      chk(tag, int'(grant_o), (m_g < 0) ? 0 : (1 << m_g));
      for (int t = 0; t < 2; t++) begin
        chk("R9 count", int'(dispatch_cnt_o[t]), m_cnt[t]);
        chk("R10 starve", int'(starve_o[t]), (m_sc[t] == 64) ? 1 : 0);
      end
      seen = int'(grant_o);
      if (grant_o[0]) win0++;
      if (grant_o[1]) win1++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin m_rp[t] = 0; m_cr[t] = 0; m_cnt[t] = 0; m_sc[t] = 0; end
      m_last = 1; m_g = -1; m_mode = 0;
    end else begin
      if (m_mode == 3) for (int t = 0; t < 2; t++) begin m_rp[t] = nrp[t]; m_cr[t] = nrp[t]; end
      if (m_mode == 1 || m_mode == 3) m_cr[m_g]--;
      if (m_g >= 0) begin
        m_last = m_g;
        m_cnt[m_g] = (m_cnt[m_g] + int'(thr_size_i[m_g])) & 16'hFFFF;
      end
      for (int t = 0; t < 2; t++)
        if (!thr_valid_i[t] || m_g == t) m_sc[t] = 0;
        else if (m_sc[t] < 64) m_sc[t]++;
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; thr_valid_i = '0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic clr();
    win0 = 0; win1 = 0;
  endtask

  initial begin
    // R11: reset state
    do_reset();
    tag = "R11";
    chk("R11 cnt0", int'(dispatch_cnt_o[0]), 0);
    chk("R11 cnt1", int'(dispatch_cnt_o[1]), 0);
    chk("R11 starve", int'(starve_o), 0);
    #2; chk("R11 no grant when idle", int'(grant_o), 0);

    // R2: equal weights alternate, thread 0 first
    do_reset(); tag = "R2";
    thr_prio_i[0] = 5'd3; thr_prio_i[1] = 5'd3; thr_valid_i = 2'b11;
    thr_size_i[0] = 3'd1; thr_size_i[1] = 3'd2;
    clr(); cyc(1);
    chk("R2 first grant", seen, 1);
    cyc(11);
    chk("R2 t0 grants", win0, 6);
    chk("R2 t1 grants", win1, 6);

    // R3 and R9: 4:2 share and instruction totals
    do_reset(); tag = "R3";
    thr_prio_i[0] = 5'd4; thr_prio_i[1] = 5'd2; thr_valid_i = 2'b11;
    thr_size_i[0] = 3'd5; thr_size_i[1] = 3'd1;
    clr(); cyc(12);
    chk("R3 t0 grants", win0, 8);
    chk("R3 t1 grants", win1, 4);
    chk("R9 t0 total", int'(dispatch_cnt_o[0]), 40);
    chk("R9 t1 total", int'(dispatch_cnt_o[1]), 4);

    // R4: top weight starves the other thread
    do_reset(); tag = "R4";
    thr_prio_i[0] = 5'd31; thr_prio_i[1] = 5'd7; thr_valid_i = 2'b11;
    clr(); cyc(40);
    chk("R4 t0 grants", win0, 40);
    chk("R4 t1 grants", win1, 0);
    thr_valid_i = 2'b10;
    clr(); cyc(5);
    chk("R4 t1 still shut out", win1, 0);

    // R5 and R10: zero weight never granted, starvation flag timing
    do_reset(); tag = "R5";
    thr_prio_i[0] = 5'd0; thr_prio_i[1] = 5'd3; thr_valid_i = 2'b11;
    clr(); cyc(10);
    chk("R5 t0 grants", win0, 0);
    chk("R5 t1 grants", win1, 10);
    thr_valid_i = 2'b01;
    clr(); cyc(10);
    chk("R5 disabled thread idle while peer stalls", win0, 0);
    cyc(43);
    chk("R10 flag low at 63", int'(starve_o[0]), 0);
    cyc(1);
    chk("R10 flag high at 64", int'(starve_o[0]), 1);
    thr_valid_i = 2'b00; cyc(1);
    chk("R10 flag clears", int'(starve_o[0]), 0);

    // R6: handover keeps the stalled thread's share
    do_reset(); tag = "R6";
    thr_prio_i[0] = 5'd1; thr_prio_i[1] = 5'd1; thr_valid_i = 2'b11;
    cyc(1);
    thr_valid_i = 2'b01;
    clr(); cyc(3);
    chk("R6 handover grants", win0, 3);
    thr_valid_i = 2'b11;
    cyc(1);
    chk("R6 share kept", seen, 2);
    cyc(1);
    chk("R6 new round", seen, 1);

    // R7: idle cycles hold credit
    do_reset(); tag = "R7";
    thr_prio_i[0] = 5'd2; thr_prio_i[1] = 5'd1; thr_valid_i = 2'b11;
    cyc(1);
    thr_valid_i = 2'b00;
    clr(); cyc(4);
    chk("R7 no grants idle", win0 + win1, 0);
    thr_valid_i = 2'b11; cyc(1);
    chk("R7 credits held", seen, 2);

    // R8: weight change waits for next round
    do_reset(); tag = "R8";
    thr_prio_i[0] = 5'd2; thr_prio_i[1] = 5'd2; thr_valid_i = 2'b11;
    cyc(1);
    thr_prio_i[0] = 5'd5; thr_prio_i[1] = 5'd0;
    clr(); cyc(3);
    chk("R8 old round t1", win1, 2);
    chk("R8 old round t0", win0, 1);
    clr(); cyc(10);
    chk("R8 new weights t1", win1, 0);
    chk("R8 new weights t0", win0, 10);

    // R1: random traffic against the model
    do_reset(); tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      if (i % 37 == 0)
        for (int t = 0; t < 2; t++)
          case ($urandom % 7)
            0: thr_prio_i[t] = 5'd0;
            1: thr_prio_i[t] = 5'd31;
            2: thr_prio_i[t] = 5'd1;
            3: thr_prio_i[t] = 5'd2;
            default: thr_prio_i[t] = 5'($urandom % 32);
          endcase
      thr_valid_i = 2'($urandom % 4);
      thr_size_i[0] = 3'(1 + $urandom % 5);
      thr_size_i[1] = 3'(1 + $urandom % 5);
      cyc(1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule